// File: doc/BRIEF.md
# PCI Configuration Status Register

This block holds the 16-bit status word of a PCI device's configuration header. Sticky flags record bus events reported by the bus interface: aborts, system error, detected parity error and reported data parity. Fixed fields describe the device's capabilities. The value is presented continuously as read data for configuration reads.

A configuration write can only clear bits. Every bit whose write data is one, inside a byte lane whose byte enable is asserted, is cleared. All other bits are untouched. Two bits are gated by command-register enables:

- Interrupt status follows the interrupt line only while interrupts are not disabled.
- Reported data parity is set only while parity-error response is enabled.

Those two bits are also mirrored toward the local side.

Top module: `pci_stat_reg`

## Requirements
- R1: After reset, with default parameters, `rd_data` reads 0x0400 and `loc_stat` reads zero.
- R2: A write with `cfg_wr` high and both byte enables set clears exactly the bits where `cfg_wdata` is one. Bits where `cfg_wdata` is zero keep their value. For example, writing 0x4000 clears only bit 14.
- R3: Reserved bits 2..0 and 7..6 always read zero, including after a write of all ones.
- R4: Bit 3 (interrupt status) reads one in the cycle after the rising clock edge at which `inta_n` is low and `cmd_int_off` is low. Otherwise it reads zero. Writes do not affect it. It is mirrored on `loc_stat[6]`.
- R5: Bits 4 and 5 read the parameters `CAP_LIST` and `CLK66_OK`. Writes do not change them.
- R6: Bits 10..9 always read binary 10, and writes do not change them.
- R7: Bit 8 is set by a pulse on `perr_drv_mst_rd` or on `perr_drv_tgt_wr`, but only while `cmd_perr_resp` is one. Once set it stays set until it is cleared by a write. It is mirrored on `loc_stat[0]`.
- R8: A pulse on `evt[i]` sets status bit 11+i, and the bit stays set until it is cleared by a write. The event order is: 0 signaled target abort, 1 received target abort, 2 received master abort, 3 signaled system error, 4 detected parity error.
- R9: If a set condition and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R10: `cfg_be[0]` qualifies bits 7..0 and `cfg_be[1]` qualifies bits 15..8. A one in a lane whose enable is low clears nothing.
- R11: While `cfg_wr` is low, `cfg_wdata` and `cfg_be` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_int_off | input | 1 | Interrupt-disable bit from the command register |
| cmd_perr_resp | input | 1 | Parity-error-response enable from the command register |
| inta_n | input | 1 | Active-low interrupt line level |
| perr_drv_mst_rd | input | 1 | Pulse: parity error output driven as master on a read |
| perr_drv_tgt_wr | input | 1 | Pulse: parity error output driven as target on a write |
| evt | input | 5 | Event pulses for status bits 15..11 |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Write data (ones select bits to clear) |
| cfg_be | input | 2 | Byte enables, bit 0 for the low byte |
| rd_data | output | 16 | Current register value |
| loc_stat | output | 7 | Local mirror: bit 6 interrupt status, bit 0 reported parity, others zero |

## Verification
The hardest case to reach from the ports is a collision: an event pulse and a clear of the same bit arriving at the same clock edge. It is also easy to disguise, because a set that wins looks exactly like a set on the following cycle. The bench first sets the flag, then drives the event pulse and the clearing write in the same cycle. It then reads the bit back, and finally issues a lone clear to show that the bit was genuinely still set. The parity-report gate is exercised the same way: pulses arrive with the enable low, and the enable is dropped while the bit is already set.

// File: rtl/pcistat_pkg.sv
package pcistat_pkg;
   localparam int STAT_W       = 16;
   localparam int POS_INT      = 3;
   localparam int POS_CAP      = 4;
   localparam int POS_66       = 5;
   localparam int POS_PERR_RPT = 8;
   localparam int POS_DSEL_LO  = 9;
   localparam int POS_EVT_BASE = 11;
   localparam int N_EVT        = 5;
   localparam int LOC_INT      = 6;
   localparam int LOC_PERR     = 0;
   localparam logic [1:0] DSEL_SLOW = 2'b10;

   typedef enum logic [2:0] {
      EV_SIG_TABT = 3'd0,
      EV_RCV_TABT = 3'd1,
      EV_RCV_MABT = 3'd2,
      EV_SIG_SERR = 3'd3,
      EV_DET_PERR = 3'd4
   } stat_evt_e;
endpackage

// File: rtl/stat_clr_mask.sv
module stat_clr_mask #(
   parameter int REG_W  = 16,
   parameter int LANE_W = 8,
   localparam int N_LANE = REG_W / LANE_W
) (
   input  logic              wr,
   input  logic [REG_W-1:0]  wdata,
   input  logic [N_LANE-1:0] be,
   output logic [REG_W-1:0]  clr
);
   generate
      if (REG_W % LANE_W != 0) begin : g_bad_lane
         $error("stat_clr_mask: REG_W must be a multiple of LANE_W");
      end
      for (genvar l = 0; l < N_LANE; l++) begin : g_lane
         assign clr[l*LANE_W +: LANE_W] =
            (wr && be[l]) ? wdata[l*LANE_W +: LANE_W] : '0;
      end
   endgenerate
endmodule

// File: rtl/stat_flag.sv
module stat_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end

   assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> q);
   assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !q);
   assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!set && !clr) |=> $stable(q));
endmodule

// File: rtl/stat_int_track.sv
module stat_int_track (
   input  logic clk,
   input  logic rst_n,
   input  logic int_off,
   input  logic inta_n,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= !int_off && !inta_n;
   end

   assert_int_seen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_off && !inta_n) |=> q);
   assert_int_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (int_off || inta_n) |=> !q);
endmodule

// File: rtl/pci_stat_reg.sv
module pci_stat_reg
   import pcistat_pkg::*;
#(
   parameter int   REG_W    = 16,
   parameter int   LANE_W   = 8,
   parameter int   LOC_W    = 7,
   parameter logic CAP_LIST = 1'b0,
   parameter logic CLK66_OK = 1'b0,
   localparam int  N_LANE   = REG_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_int_off,
   input  logic              cmd_perr_resp,
   input  logic              inta_n,
   input  logic              perr_drv_mst_rd,
   input  logic              perr_drv_tgt_wr,
   input  logic [N_EVT-1:0]  evt,
   input  logic              cfg_wr,
   input  logic [REG_W-1:0]  cfg_wdata,
   input  logic [N_LANE-1:0] cfg_be,
   output logic [REG_W-1:0]  rd_data,
   output logic [LOC_W-1:0]  loc_stat
);
   generate
      if (REG_W != STAT_W) begin : g_bad_width
         $error("pci_stat_reg: REG_W must equal STAT_W");
      end
      if (LOC_W <= LOC_INT) begin : g_bad_loc
         $error("pci_stat_reg: LOC_W too small for mirror");
      end
   endgenerate

   logic [REG_W-1:0] clr;
   logic             int_q;
   logic             perr_q;
   logic             perr_set;
   logic [N_EVT-1:0] evt_q;

   stat_clr_mask #(.REG_W(REG_W), .LANE_W(LANE_W)) u_mask (
      .wr(cfg_wr), .wdata(cfg_wdata), .be(cfg_be), .clr(clr)
   );

   stat_int_track u_int (
      .clk(clk), .rst_n(rst_n), .int_off(cmd_int_off),
      .inta_n(inta_n), .q(int_q)
   );

   assign perr_set = cmd_perr_resp && (perr_drv_mst_rd || perr_drv_tgt_wr);

   stat_flag u_perr (
      .clk(clk), .rst_n(rst_n), .set(perr_set),
      .clr(clr[POS_PERR_RPT]), .q(perr_q)
   );

   generate
      for (genvar i = 0; i < N_EVT; i++) begin : g_evt
         stat_flag u_flag (
            .clk(clk), .rst_n(rst_n), .set(evt[i]),
            .clr(clr[POS_EVT_BASE+i]), .q(evt_q[i])
         );
      end
   endgenerate

   always_comb begin
      rd_data                            = '0;
      rd_data[POS_INT]                   = int_q;
      rd_data[POS_CAP]                   = CAP_LIST;
      rd_data[POS_66]                    = CLK66_OK;
      rd_data[POS_PERR_RPT]              = perr_q;
      rd_data[POS_DSEL_LO +: 2]          = DSEL_SLOW;
      rd_data[POS_EVT_BASE +: N_EVT]     = evt_q;
   end

   always_comb begin
      loc_stat           = '0;
      loc_stat[LOC_INT]  = int_q;
      loc_stat[LOC_PERR] = perr_q;
   end

   assert_perr_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_perr_resp && !rd_data[POS_PERR_RPT]) |=> !rd_data[POS_PERR_RPT]);
   assert_no_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr && cfg_be[1]) |=>
      ((rd_data[REG_W-1:LANE_W] & $past(rd_data[REG_W-1:LANE_W]))
        == $past(rd_data[REG_W-1:LANE_W])));
   assert_idle_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_wr && evt == '0 && !perr_set && $stable(rd_data[REG_W-1:LANE_W]))
      |=> $stable(rd_data[REG_W-1:LANE_W]));
endmodule

// File: tb/pci_stat_reg_test.sv
module pci_stat_reg_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmd_int_off, cmd_perr_resp, inta_n;
   logic        perr_drv_mst_rd, perr_drv_tgt_wr;
   logic [4:0]  evt;
   logic        cfg_wr;
   logic [15:0] cfg_wdata;
   logic [1:0]  cfg_be;
   logic [15:0] rd_data, rd_cfg;
   logic [6:0]  loc_stat, loc_cfg;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   pci_stat_reg uut (
      .clk(clk), .rst_n(rst_n), .cmd_int_off(cmd_int_off),
      .cmd_perr_resp(cmd_perr_resp), .inta_n(inta_n),
      .perr_drv_mst_rd(perr_drv_mst_rd), .perr_drv_tgt_wr(perr_drv_tgt_wr),
      .evt(evt), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_be(cfg_be),
      .rd_data(rd_data), .loc_stat(loc_stat)
   );

   pci_stat_reg #(.CAP_LIST(1'b1), .CLK66_OK(1'b1)) uut_cfg (
      .clk(clk), .rst_n(rst_n), .cmd_int_off(cmd_int_off),
      .cmd_perr_resp(cmd_perr_resp), .inta_n(inta_n),
      .perr_drv_mst_rd(perr_drv_mst_rd), .perr_drv_tgt_wr(perr_drv_tgt_wr),
      .evt(evt), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_be(cfg_be),
      .rd_data(rd_cfg), .loc_stat(loc_cfg)
   );

   task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got 0x%04h expected 0x%04h", req, got, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic pulse(logic [4:0] e);
      evt = e;
      step();
      evt = '0;
   endtask

   task automatic wr(logic [15:0] d, logic [1:0] be);
      cfg_wr = 1'b1; cfg_wdata = d; cfg_be = be;
      step();
      cfg_wr = 1'b0; cfg_wdata = '0; cfg_be = '0;
   endtask

   task automatic t_reset();
      chk("R1 reset value", rd_data, 16'h0400);
      chk("R1 reset mirror", {9'd0, loc_stat}, 16'h0000);
   endtask

   task automatic t_events();
      pulse(5'b00001);
      chk("R8 signaled target abort bit 11", rd_data, 16'h0C00);
      step();
      chk("R8 flag sticky", rd_data, 16'h0C00);
      wr(16'hFFFF, 2'b11);
      pulse(5'b00100);
      chk("R8 master abort bit 13", rd_data, 16'h2400);
      pulse(5'b11111);
      chk("R8 all events", rd_data, 16'hFC00);
   endtask

   task automatic t_w1c();
      wr(16'h4000, 2'b11);
      chk("R2 clear bit 14 only", rd_data, 16'hBC00);
      wr(16'h0000, 2'b11);
      chk("R2 zero write keeps bits", rd_data, 16'hBC00);
      wr(16'hFFFF, 2'b11);
      chk("R2 clear all", rd_data, 16'h0400);
   endtask

   task automatic t_perr();
      cmd_perr_resp = 1'b0;
      perr_drv_mst_rd = 1'b1; step(); perr_drv_mst_rd = 1'b0;
      chk("R7 gated off", rd_data, 16'h0400);
      cmd_perr_resp = 1'b1;
      perr_drv_mst_rd = 1'b1; step(); perr_drv_mst_rd = 1'b0;
      chk("R7 master read sets", rd_data, 16'h0500);
      chk("R7 mirror bit 0", {9'd0, loc_stat}, 16'h0001);
      wr(16'h0100, 2'b11);
      chk("R7 cleared", rd_data, 16'h0400);
      perr_drv_tgt_wr = 1'b1; step(); perr_drv_tgt_wr = 1'b0;
      chk("R7 target write sets", rd_data, 16'h0500);
      cmd_perr_resp = 1'b0;
      step();
      chk("R7 sticky after enable drop", rd_data, 16'h0500);
      wr(16'h0100, 2'b11);
   endtask

   task automatic t_byte_en();
      cmd_perr_resp = 1'b1;
      evt = 5'b11111; perr_drv_tgt_wr = 1'b1; step();
      evt = '0; perr_drv_tgt_wr = 1'b0; cmd_perr_resp = 1'b0;
      wr(16'hFFFF, 2'b01);
      chk("R10 low lane only, upper kept", rd_data, 16'hFD00);
      cfg_wr = 1'b0; cfg_wdata = 16'hFFFF; cfg_be = 2'b11; step();
      cfg_wdata = '0; cfg_be = '0;
      chk("R11 data without strobe ignored", rd_data, 16'hFD00);
      wr(16'hFFFF, 2'b10);
      chk("R10 upper lane clears", rd_data, 16'h0400);
   endtask

   task automatic t_int();
      inta_n = 1'b0; cmd_int_off = 1'b0; step();
      chk("R4 interrupt seen", rd_data, 16'h0408);
      chk("R4 mirror bit 6", {9'd0, loc_stat}, 16'h0040);
      wr(16'hFFFF, 2'b11);
      chk("R4 write does not clear", rd_data, 16'h0408);
      chk("R3 reserved zero", rd_data & 16'h00C7, 16'h0000);
      cmd_int_off = 1'b1; step();
      chk("R4 disabled", rd_data, 16'h0400);
      cmd_int_off = 1'b0; inta_n = 1'b1; step();
      chk("R4 line released", rd_data, 16'h0400);
   endtask

   task automatic t_ro();
      wr(16'hFFFF, 2'b11);
      chk("R6 devsel field after write", rd_data & 16'h0600, 16'h0400);
      chk("R3 reserved after all-ones", rd_data & 16'h00C7, 16'h0000);
      chk("R5 param bits fixed", rd_cfg, 16'h0430);
      chk("R5 default params zero", rd_data & 16'h0030, 16'h0000);
   endtask

   task automatic t_collision();
      pulse(5'b00010);
      evt = 5'b00010; cfg_wr = 1'b1; cfg_wdata = 16'h1000; cfg_be = 2'b11;
      step();
      evt = '0; cfg_wr = 1'b0; cfg_wdata = '0; cfg_be = '0;
      chk("R9 set wins over clear", rd_data, 16'h1400);
      wr(16'h1000, 2'b11);
      chk("R9 lone clear after", rd_data, 16'h0400);
      cmd_perr_resp = 1'b1;
      perr_drv_mst_rd = 1'b1; cfg_wr = 1'b1; cfg_wdata = 16'h0100; cfg_be = 2'b11;
      step();
      perr_drv_mst_rd = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; cfg_be = '0;
      cmd_perr_resp = 1'b0;
      chk("R9 parity set wins", rd_data, 16'h0500);
      wr(16'h0100, 2'b11);
   endtask

   initial begin
      rst_n = 1'b0; cmd_int_off = 1'b0; cmd_perr_resp = 1'b0; inta_n = 1'b1;
      perr_drv_mst_rd = 1'b0; perr_drv_tgt_wr = 1'b0; evt = '0;
      cfg_wr = 1'b0; cfg_wdata = '0; cfg_be = '0;
      step(); step();
      rst_n = 1'b1;
      step();
      t_reset();
      chk("R5 param reset", rd_cfg, 16'h0430);
      t_events();
      t_w1c();
      t_perr();
      t_byte_en();
      t_int();
      t_ro();
      t_collision();
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int n = 0; n < 5000; n++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule